// File: doc/BRIEF.md
# Coalescing Register Write Packer

The packer takes a stream of register write requests, each an offset and a 32-bit value. It lays them out as a command buffer in a local memory that is addressed by dword. A consumer elsewhere in the chip later fetches that buffer and replays the writes. Every write first becomes a two-dword instruction. When the same register is written again at once, the packer rewrites the single instruction it has already placed into a burst. The burst starts with a count, and later values are appended to it. A burst with an odd number of values always has a zero dword right after it, so the next instruction still starts on an even dword.

A finish request fills the rest of the current 16-dword (64-byte) block with zeros and moves the free pointer to that boundary. It then raises a done flag. A request that would run past the end of the buffer is dropped and sets a sticky overflow flag. The tail output gives the used length in bytes. A read port exposes the buffer contents.

Top module: `coalescing_write_packer`

## Requirements
- R1: A write that does not extend the previous instruction places two dwords. The value goes at the even index `p`. At `p+1` goes the header: 0x01 in bits 31:24, 0xF in bits 23:20 and the offset in bits 19:0.
- R2: Every new instruction starts at an even index. If the free position is odd, it is first rounded up by one, which skips the zero pad word.
- R3: A second write to the same offset as a previous single instruction at index `s` rewrites that instruction in place. The result is: `s` holds count 2, `s+1` holds 0x09 in bits 31:24 with zero byte-enable bits and the offset, `s+2` holds the old value and `s+3` holds the new value. The free position becomes `s+4`.
- R4: Each further write to the same offset while a burst is open appends the value at the free position and increments the count dword at `s`.
- R5: When an append leaves the free position odd, the dword at the free position reads zero.
- R6: A write to a different offset, or any write after a finish, starts a new instruction.
- R7: A write arriving when the free position exceeds DEPTH-2 is dropped without changing the buffer or the tail. It sets `ovf`, which stays high until clear or reset.
- R8: A finish zero-fills from the free position up to the next multiple of 16 dwords and moves the free position there. It then asserts `done`. A finish at a position that is already aligned changes nothing and asserts `done` at once.
- R9: `tail_bytes` always equals four times the free position.
- R10: Reset or `clr` returns the tail, `ovf` and `done` to zero and forgets the open instruction.
- R11: `req_ready` is low for a fixed number of cycles after each accepted request:
  - a new instruction: 1
  - a conversion into a burst: 3
  - an append: 2 if the pad word is needed, otherwise 1
  - a finish: one cycle per pad dword
  - a dropped write: 0

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the packing state |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Packer can accept a request |
| req_fin | input | 1 | 1 = finish request, 0 = register write |
| req_ofs | input | OFS_W | Register offset |
| req_val | input | 32 | Register value |
| rd_addr | input | $clog2(DEPTH) | Buffer read address |
| rd_data | output | 32 | Buffer dword at `rd_addr` |
| tail_bytes | output | $clog2(DEPTH+1)+2 | Used length in bytes |
| done | output | 1 | Finish completed; cleared by the next accepted request |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The bench sweeps run lengths of one to five writes to a single offset, each followed by a different offset and a finish. It compares every dword against a buffer computed arithmetically, which catches three kinds of error:
- a conversion that leaves byte enables in the burst header
- a count that is off by one
- a second instruction that starts on an odd dword and overlaps the pad

It fills the buffer with both single and burst instructions until requests are dropped. A limit that is off by one would either write past the end or refuse the final slot. It also checks that a write after a finish and a write after a clear both start a fresh instruction rather than appending to a stale burst. The handshake stall lengths are measured, so a sequence that skipped or repeated a memory step would show up.

// File: rtl/pkr_pkg.sv
package pkr_pkg;

   typedef enum logic [1:0] {
      LK_NONE,
      LK_SINGLE,
      LK_BURST
   } last_kind_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_NEW2,
      S_CV1,
      S_CV2,
      S_CV3,
      S_AP1,
      S_AP2,
      S_PAD
   } pack_st_e;

   localparam logic [7:0] OP_SINGLE = 8'h01;
   localparam logic [7:0] OP_BURST  = 8'h09;
   localparam logic [3:0] BE_ALL    = 4'hF;

   function automatic logic [31:0] single_hdr(input logic [19:0] ofs);
      return {OP_SINGLE, BE_ALL, ofs};
   endfunction

   function automatic logic [31:0] burst_hdr(input logic [19:0] ofs);
      return {OP_BURST, 4'h0, ofs};
   endfunction

endpackage

// File: rtl/pkr_mem.sv
module pkr_mem #(
   parameter int DEPTH  = 64,
   parameter bit RD_REG = 1'b0,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [31:0]   wdata,
   input  logic [AW-1:0] raddr,
   output logic [31:0]   rdata
);

   logic [31:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
   end

   generate
      if (RD_REG) begin : g_rd_reg
         always_ff @(posedge clk) rdata <= store[raddr];
      end else begin : g_rd_comb
         assign rdata = store[raddr];
      end
   endgenerate

endmodule

// File: rtl/pkr_ctrl.sv
module pkr_ctrl
   import pkr_pkg::*;
#(
   parameter int DEPTH       = 64,
   parameter int OFS_W       = 20,
   parameter int ALIGN_WORDS = 16,
   localparam int AW         = $clog2(DEPTH),
   localparam int PW         = $clog2(DEPTH + 1),
   localparam int LW         = $clog2(ALIGN_WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             req_valid,
   input  logic             req_fin,
   input  logic [OFS_W-1:0] req_ofs,
   input  logic [31:0]      req_val,
   output logic             req_ready,
   output logic             mem_we,
   output logic [AW-1:0]    mem_waddr,
   output logic [31:0]      mem_wdata,
   output logic [PW-1:0]    fp,
   output logic             done,
   output logic             ovf
);

   localparam logic [PW-1:0] LIMIT = PW'(DEPTH - 2);

   pack_st_e          st;
   last_kind_e        kind;
   logic [PW-1:0]     ins;
   logic [PW-1:0]     cnt;
   logic [OFS_W-1:0]  last_ofs;
   logic [31:0]       last_val;
   logic [OFS_W-1:0]  cur_ofs;
   logic [31:0]       cur_val;

   logic              acc, full, match, aligned, nxt_aligned;
   logic [PW-1:0]     pos, fp_inc, wa;

   assign req_ready   = (st == S_IDLE);
   assign acc         = req_valid && req_ready;
   assign full        = fp > LIMIT;
   assign match       = (kind != LK_NONE) && (last_ofs == req_ofs);
   assign pos         = fp + PW'(fp[0]);
   assign fp_inc      = fp + PW'(1);
   assign aligned     = (fp[LW-1:0] == '0);
   assign nxt_aligned = (fp_inc[LW-1:0] == '0);

   // one memory word per cycle
   always_comb begin
      mem_we    = 1'b0;
      wa        = '0;
      mem_wdata = '0;
      unique case (st)
         S_IDLE: begin
            if (acc && !req_fin && !full) begin
               mem_we = 1'b1;
               if (match && kind == LK_SINGLE) begin
                  wa        = ins;
                  mem_wdata = 32'd2;
               end else if (match) begin
                  wa        = fp;
                  mem_wdata = req_val;
               end else begin
                  wa        = pos;
                  mem_wdata = req_val;
               end
            end
         end
         S_NEW2: begin
            mem_we    = 1'b1;
            wa        = ins + PW'(1);
            mem_wdata = single_hdr(20'(cur_ofs));
         end
         S_CV1: begin
            mem_we    = 1'b1;
            wa        = ins + PW'(1);
            mem_wdata = burst_hdr(20'(last_ofs));
         end
         S_CV2: begin
            mem_we    = 1'b1;
            wa        = ins + PW'(2);
            mem_wdata = last_val;
         end
         S_CV3: begin
            mem_we    = 1'b1;
            wa        = ins + PW'(3);
            mem_wdata = cur_val;
         end
         S_AP1: begin
            mem_we    = 1'b1;
            wa        = ins;
            mem_wdata = 32'(cnt + PW'(1));
         end
         S_AP2, S_PAD: begin
            mem_we    = 1'b1;
            wa        = fp;
            mem_wdata = '0;
         end
         default: ;
      endcase
   end

   assign mem_waddr = AW'(wa);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         kind     <= LK_NONE;
         fp       <= '0;
         ins      <= '0;
         cnt      <= '0;
         last_ofs <= '0;
         last_val <= '0;
         cur_ofs  <= '0;
         cur_val  <= '0;
         done     <= 1'b0;
         ovf      <= 1'b0;
      end else if (clr) begin
         st   <= S_IDLE;
         kind <= LK_NONE;
         fp   <= '0;
         ins  <= '0;
         cnt  <= '0;
         done <= 1'b0;
         ovf  <= 1'b0;
      end else begin
         unique case (st)
            S_IDLE: begin
               if (acc) begin
                  done <= 1'b0;
                  if (req_fin) begin
                     kind <= LK_NONE;
                     if (aligned) done <= 1'b1;
                     else         st   <= S_PAD;
                  end else if (full) begin
                     ovf <= 1'b1;
                  end else if (match && kind == LK_SINGLE) begin
                     cur_val <= req_val;
                     st      <= S_CV1;
                  end else if (match) begin
                     fp <= fp_inc;
                     st <= S_AP1;
                  end else begin
                     ins     <= pos;
                     cur_ofs <= req_ofs;
                     cur_val <= req_val;
                     st      <= S_NEW2;
                  end
               end
            end
            S_NEW2: begin
               fp       <= ins + PW'(2);
               kind     <= LK_SINGLE;
               last_ofs <= cur_ofs;
               last_val <= cur_val;
               st       <= S_IDLE;
            end
            S_CV1: st <= S_CV2;
            S_CV2: st <= S_CV3;
            S_CV3: begin
               fp   <= ins + PW'(4);
               kind <= LK_BURST;
               cnt  <= PW'(2);
               st   <= S_IDLE;
            end
            S_AP1: begin
               cnt <= cnt + PW'(1);
               st  <= fp[0] ? S_AP2 : S_IDLE;
            end
            S_AP2: st <= S_IDLE;
            S_PAD: begin
               fp <= fp_inc;
               if (nxt_aligned) begin
                  done <= 1'b1;
                  st   <= S_IDLE;
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   // R9
   fp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fp <= PW'(DEPTH));

   // R2
   even_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kind != LK_NONE) |-> !ins[0]);

   // R7
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !clr) |=> ovf);

   // R7
   drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !req_fin && full && !clr) |=> (fp == $past(fp)));

   // R8
   pad_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> (fp[LW-1:0] == '0));

endmodule

// File: rtl/coalescing_write_packer.sv
module coalescing_write_packer #(
   parameter int DEPTH       = 64,
   parameter int OFS_W       = 20,
   parameter int ALIGN_WORDS = 16,
   parameter bit RD_REG      = 1'b0,
   localparam int AW         = $clog2(DEPTH),
   localparam int PW         = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic             req_fin,
   input  logic [OFS_W-1:0] req_ofs,
   input  logic [31:0]      req_val,
   input  logic [AW-1:0]    rd_addr,
   output logic [31:0]      rd_data,
   output logic [PW+1:0]    tail_bytes,
   output logic             done,
   output logic             ovf
);

   generate
      if (DEPTH < ALIGN_WORDS || DEPTH % ALIGN_WORDS != 0) begin : g_bad_depth
         $error("DEPTH must be a positive multiple of ALIGN_WORDS");
      end
      if (ALIGN_WORDS < 4 || (ALIGN_WORDS & (ALIGN_WORDS - 1)) != 0) begin : g_bad_align
         $error("ALIGN_WORDS must be a power of two of at least 4");
      end
      if (OFS_W < 1 || OFS_W > 20) begin : g_bad_ofs
         $error("OFS_W must lie in 1..20");
      end
   endgenerate

   logic          mem_we;
   logic [AW-1:0] mem_waddr;
   logic [31:0]   mem_wdata;
   logic [PW-1:0] fp;

   pkr_ctrl #(
      .DEPTH       (DEPTH),
      .OFS_W       (OFS_W),
      .ALIGN_WORDS (ALIGN_WORDS)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .req_valid (req_valid),
      .req_fin   (req_fin),
      .req_ofs   (req_ofs),
      .req_val   (req_val),
      .req_ready (req_ready),
      .mem_we    (mem_we),
      .mem_waddr (mem_waddr),
      .mem_wdata (mem_wdata),
      .fp        (fp),
      .done      (done),
      .ovf       (ovf)
   );

   pkr_mem #(
      .DEPTH  (DEPTH),
      .RD_REG (RD_REG)
   ) u_mem (
      .clk   (clk),
      .we    (mem_we),
      .waddr (mem_waddr),
      .wdata (mem_wdata),
      .raddr (rd_addr),
      .rdata (rd_data)
   );

   assign tail_bytes = {fp, 2'b00};

endmodule

// File: tb/tb_coalescing_write_packer.sv
module tb_coalescing_write_packer;

   localparam int DEPTH = 64;
   localparam int AW    = 6;
   localparam int PW    = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clr = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_fin = 1'b0;
   logic [19:0]   req_ofs = '0;
   logic [31:0]   req_val = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [31:0]   rd_data;
   logic [PW+1:0] tail_bytes;
   logic          done, ovf;

   always #2.5 clk = ~clk;

   coalescing_write_packer #(.DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .req_valid(req_valid), .req_ready(req_ready), .req_fin(req_fin),
      .req_ofs(req_ofs), .req_val(req_val),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .tail_bytes(tail_bytes), .done(done), .ovf(ovf)
   );

   int checks = 0;
   int errors = 0;

   // arithmetic buffer model
   logic [31:0] m [DEPTH];
   int          fp_m = 0, ins_m = 0, kind_m = 0, cnt_m = 0;
   logic [19:0] lofs_m = '0;
   logic [31:0] lval_m = '0;
   bit          ovf_m = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic model_clear();
      fp_m = 0; ins_m = 0; kind_m = 0; cnt_m = 0; ovf_m = 0;
   endtask

   task automatic wait_ready();
      while (!req_ready) @(negedge clk);
   endtask

   task automatic issue(input bit fin, input logic [19:0] o,
                        input logic [31:0] v, output int lowc);
      wait_ready();
      req_valid = 1'b1; req_fin = fin; req_ofs = o; req_val = v;
      @(negedge clk);
      req_valid = 1'b0; req_fin = 1'b0;
      lowc = 0;
      while (!req_ready) begin
         lowc++;
         @(negedge clk);
      end
   endtask

   // write with model update; returns expected stall
   task automatic wr(input logic [19:0] o, input logic [31:0] v, input string req);
      int exp_low, lowc;
      if (fp_m > DEPTH - 2) begin
         ovf_m = 1; exp_low = 0;
      end else if (kind_m == 1 && lofs_m == o) begin
         m[ins_m] = 2; m[ins_m+1] = {8'h09, 4'h0, o};
         m[ins_m+2] = lval_m; m[ins_m+3] = v;
         fp_m = ins_m + 4; kind_m = 2; cnt_m = 2; exp_low = 3;
      end else if (kind_m == 2 && lofs_m == o) begin
         m[fp_m] = v; fp_m++; cnt_m++; m[ins_m] = cnt_m;
         exp_low = 1;
         if (fp_m % 2 == 1) begin m[fp_m] = 0; exp_low = 2; end
      end else begin
         int p = fp_m + (fp_m % 2);
         m[p] = v; m[p+1] = {8'h01, 4'hF, o};
         ins_m = p; fp_m = p + 2; kind_m = 1; lofs_m = o; lval_m = v;
         exp_low = 1;
      end
      issue(1'b0, o, v, lowc);
      // R11 stall length
      chk(lowc == exp_low, "R11", {req, " stall"}, lowc, exp_low);
      // R9
      chk(tail_bytes == PW'(fp_m) * 4, "R9", {req, " tail"}, tail_bytes, fp_m * 4);
   endtask

   task automatic finish(input string req);
      int lowc, exp_low;
      exp_low = (16 - fp_m % 16) % 16;
      while (fp_m % 16 != 0) begin m[fp_m] = 0; fp_m++; end
      kind_m = 0;
      issue(1'b1, '0, '0, lowc);
      // R8
      chk(done == 1'b1, req, "done after finish", done, 1);
      chk(lowc == exp_low, "R11", "finish stall", lowc, exp_low);
      chk(tail_bytes == PW'(fp_m) * 4, req, "tail after finish", tail_bytes, fp_m * 4);
   endtask

   task automatic check_buf(input string req, input int upto);
      for (int i = 0; i < upto; i++) begin
         rd_addr = AW'(i);
         #1;
         chk(rd_data == m[i], req, $sformatf("word %0d", i), rd_data, m[i]);
      end
      @(negedge clk);
   endtask

   task automatic do_clear();
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0;
      model_clear();
      // R10
      chk(tail_bytes == 0, "R10", "tail after clear", tail_bytes, 0);
      chk(ovf == 0, "R10", "ovf after clear", ovf, 0);
      chk(done == 0, "R10", "done after clear", done, 0);
   endtask

   bit wd_fired = 0;
   initial begin
      repeat (100000) @(posedge clk);
      wd_fired = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(tail_bytes == 0, "R10", "tail at reset", tail_bytes, 0);
      chk(ovf == 0 && done == 0, "R10", "flags at reset", {ovf, done}, 0);
      chk(req_ready == 1, "R11", "ready at reset", req_ready, 1);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 single write format
      wr(20'h12345, 32'hCAFE0001, "R1");
      check_buf("R1", 2);

      // sweep run lengths of one offset, then another offset, then finish
      for (int run = 1; run <= 5; run++) begin
         do_clear();
         for (int k = 0; k < run; k++)
            wr(20'h00100 + 20'(run), 32'hA000_0000 + 32'(run * 16 + k), "R3 R4");
         if (fp_m % 2 == 1) begin
            // R5 pad word after odd burst
            rd_addr = AW'(fp_m); #1;
            chk(rd_data == 0, "R5", "pad word", rd_data, 0);
            chk(tail_bytes[2] == 1'b1, "R5", "odd tail", tail_bytes, fp_m * 4);
            @(negedge clk);
         end
         wr(20'h00200, 32'hB000_0000 + 32'(run), "R2 R6");
         chk(ins_m % 2 == 0 && fp_m % 2 == 0, "R2", "even start", ins_m, ins_m);
         check_buf("R4", fp_m);
         finish("R8");
         check_buf("R8", fp_m);
      end

      // R6 write after finish starts a fresh instruction
      do_clear();
      wr(20'h00033, 32'h1, "R6");
      finish("R8");
      wr(20'h00033, 32'h2, "R6");
      chk(fp_m == 18, "R6", "fresh instr end", tail_bytes, 72);
      check_buf("R6", fp_m);

      // R7 fill with singles until dropped
      do_clear();
      for (int i = 0; i < 34; i++) wr(20'(i), 32'h5000 + 32'(i), "R7");
      chk(ovf == 1, "R7", "ovf singles", ovf, 1);
      chk(tail_bytes == 256, "R7", "full tail", tail_bytes, 256);
      check_buf("R7", DEPTH);
      repeat (3) @(negedge clk);
      chk(ovf == 1, "R7", "ovf sticky", ovf, 1);
      finish("R8");   // aligned: no padding

      // R7 fill with one long burst
      do_clear();
      for (int i = 0; i < 66; i++) wr(20'h00777, 32'h9000 + 32'(i), "R7");
      chk(ovf == 1, "R7", "ovf burst", ovf, 1);
      chk(tail_bytes == 63 * 4, "R7", "burst tail", tail_bytes, 252);
      check_buf("R7", DEPTH);

      // R10 clear forgets open burst
      do_clear();
      wr(20'h00777, 32'h7777, "R10");
      chk(ins_m == 0 && kind_m == 1, "R10", "new instr at 0", tail_bytes, 8);
      check_buf("R10", 2);

      if (!wd_fired) begin
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule